// File: doc/BRIEF.md
# Trigger-Level Character Buffer with Error Tags

This block is the character buffer that sits between a serial engine and a host bus in a UART channel. It holds up to 64 characters and raises two request outputs when the buffer has reached a chosen fill point. In its receive form, each entry is 11 bits wide: the 8-bit character and 3 error-status bits captured with it. In its transmit form, each entry is 8 bits wide. The parameter `IS_RX` picks the form. On the receive side the requests count stored characters. On the transmit side they count free spaces.

The fill point comes from one of two sources. The first is a fixed table indexed by a two-bit code. The second is a programmable multiplier that sets the point at four entries per step. When buffering is switched off, the block behaves as a single holding register and the fill point is one character. A synchronous clear empties the buffer in one cycle. The host then moves data through plain valid/ready ports.

Top module: `trig_fifo`

## Requirements
- R1: After reset, buffering is off, `level` is 0, `rd_valid` is 0 and `wr_ready` is 1. The fill point is one character, so the receive form holds `irq` and `dma_rdy` low and the transmit form holds both high.
- R2: With buffering on, entries leave in write order. At most `DEPTH` (64) entries are held, and `wr_ready` is low exactly when 64 are held. An accepted write with no read raises `level` by one on the next cycle.
- R3: A read returns the whole entry that was written. In the receive form this is all 11 bits: data in bits 7:0 and error status in bits 10:8. In the transmit form it is 8 bits.
- R4: With buffering off, `wr_ready` stays 1 and `level` never exceeds 1. A write while a character is held replaces it, and a read in the same cycle returns the old character.
- R5: With the preset source in use, `trig_code` values 0, 1, 2 and 3 select fill points. In the receive form these are 8, 16, 56 and 60 stored entries. In the transmit form they are 8, 16, 32 and 56 free spaces.
- R6: When `trig_use_prog` is 1 and `trig_prog` holds N with N not 0, the fill point is 4*N. When N is 0, or `trig_use_prog` is 0, the preset applies.
- R7: `irq` is high exactly when the measured amount reaches the fill point. The receive form measures `level`; the transmit form measures free spaces, which is capacity minus `level`. Capacity is 64 with buffering on and 1 with it off. With buffering off the fill point is 1.
- R8: `dma_rdy` is high whenever `irq` is. Once high, it stays high until the buffer is empty (receive form) or has no free space (transmit form).
- R9: `fifo_clr` makes `level` 0 on the next cycle. It takes priority over a write or read in the same cycle.
- R10: A change of `fifo_en` empties the buffer. The new mode applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = 64-entry buffering, 0 = single holding register |
| fifo_clr | input | 1 | Synchronous clear of pointers and level |
| trig_code | input | 2 | Preset fill-point code |
| trig_use_prog | input | 1 | Selects the programmable fill-point source |
| trig_prog | input | PROG_W | Programmable fill-point multiplier N (point = 4*N) |
| wr_valid | input | 1 | Write data offered |
| wr_ready | output | 1 | Write can be accepted |
| wr_data | input | DATA_W | Entry to store |
| rd_valid | output | 1 | An entry is available |
| rd_ready | input | 1 | Reader takes the entry |
| rd_data | output | DATA_W | Oldest entry |
| level | output | LVL_W | Number of stored entries |
| irq | output | 1 | Fill point reached |
| dma_rdy | output | 1 | Transfer request with hold until empty or full |

## Verification
Both forms are driven with the same stimulus and checked on every clock against a queue model. A pure fill run and a pure drain run sweep `level` across every fill point while the trigger source and code change each cycle. This separates a wrong preset table, a wrong multiplier, and a wrong comparison edge (">=" against ">"). Directed overwrite and read-while-write cycles with buffering off separate single-register behaviour from queue behaviour. A long run of random mixed reads and writes, with occasional clears and mode changes, shows whether `dma_rdy` holds correctly between the fill point and the empty or full boundary, and whether clears and mode changes win over a concurrent write.

// File: rtl/tfifo_pkg.sv
// Package: shared helpers for the trigger-level character buffer.
// Holds the preset fill-point tables for the receive and transmit forms.
package tfifo_pkg;

    // Preset fill point for a two-bit code; receive counts entries, transmit counts free spaces.
    function automatic int unsigned preset_trig(input bit rx, input logic [1:0] code);
        int unsigned v;
        if (rx) begin
            case (code)
                2'd0:    v = 8;
                2'd1:    v = 16;
                2'd2:    v = 56;
                default: v = 60;
            endcase
        end else begin
            case (code)
                2'd0:    v = 8;
                2'd1:    v = 16;
                2'd2:    v = 32;
                default: v = 56;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/trig_fifo_store.sv
// Module: trig_fifo_store
// Storage array with read/write pointers and a fill counter.
// With buffering on it is a circular queue of DEPTH entries. With it off,
// the slot at the read pointer acts as one holding register that a write overwrites.
// Assumes DEPTH is a power of two and the caller never reads an empty store
// or writes a full one while buffering is on. The data array is not reset.
module trig_fifo_store #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 11,
    parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_q,
    input  logic              clear,
    input  logic              wr_do,
    input  logic              rd_do,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q, rptr_q;
    logic [LVL_W-1:0]  level_q, level_d;
    logic [AW-1:0]     wr_addr;

    // Write slot: tail of the queue when buffering, the held slot otherwise.
    assign wr_addr = en_q ? wptr_q : rptr_q;
    assign rd_data = mem[rptr_q];
    assign level   = level_q;

    // Next fill count from mode, clear and the two handshakes.
    always_comb begin
        if (clear) begin
            level_d = '0;
        end else if (en_q) begin
            level_d = level_q + {{(LVL_W-1){1'b0}}, wr_do} - {{(LVL_W-1){1'b0}}, rd_do};
        end else if (wr_do) begin
            level_d = {{(LVL_W-1){1'b0}}, 1'b1};
        end else if (rd_do) begin
            level_d = '0;
        end else begin
            level_d = level_q;
        end
    end

    // Fill counter and pointers; pointers move only while buffering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else begin
            level_q <= level_d;
            if (clear) begin
                wptr_q <= '0;
                rptr_q <= '0;
            end else if (en_q) begin
                if (wr_do) wptr_q <= wptr_q + AW'(1);
                if (rd_do) rptr_q <= rptr_q + AW'(1);
            end
        end
    end

    // Data array write; a clear discards the concurrent write.
    always_ff @(posedge clk) begin
        if (wr_do && !clear) mem[wr_addr] <= wr_data;
    end

    // R2: fill count never passes the array size.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LVL_W'(DEPTH));

    // R2: a lone accepted write raises the count by one.
    assert_write_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && wr_do && !rd_do && !clear) |=> (level_q == $past(level_q) + LVL_W'(1)));

    // R4: single holding register never holds more than one entry.
    assert_single_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (level_q <= LVL_W'(1)));

    // R9: a clear empties the store on the next cycle.
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (level_q == '0));

endmodule

// File: rtl/trig_fifo_thresh.sv
// Module: trig_fifo_thresh
// Selects the fill point (forced 1, programmable 4*N, or preset) and compares
// the measured amount with it. The receive form measures stored entries, the
// transmit form measures free spaces. Also flags the drain boundary
// (empty for receive, full for transmit). Assumes PROG_STEP*max(N) fits LVL_W.
module trig_fifo_thresh #(
    parameter int unsigned IS_RX     = 1,
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned PROG_W    = 4,
    parameter int unsigned PROG_STEP = 4,
    parameter int unsigned LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic              en_q,
    input  logic [1:0]        trig_code,
    input  logic              trig_use_prog,
    input  logic [PROG_W-1:0] trig_prog,
    input  logic [LVL_W-1:0]  level,
    output logic              hit,
    output logic              drained
);
    logic [LVL_W-1:0] trig, cap, room, measured;

    // Fill point choice: forced 1 when unbuffered, else programmable or preset.
    always_comb begin
        if (!en_q) begin
            trig = LVL_W'(1);
        end else if (trig_use_prog && (trig_prog != '0)) begin
            trig = LVL_W'(trig_prog) * LVL_W'(PROG_STEP);
        end else begin
            trig = LVL_W'(tfifo_pkg::preset_trig(IS_RX != 0, trig_code));
        end
    end

    assign cap  = en_q ? LVL_W'(DEPTH) : LVL_W'(1);
    assign room = cap - level;

    // Direction variant: what is measured and where the request drops.
    generate
        if (IS_RX != 0) begin : g_rx
            assign measured = level;
            assign drained  = (level == '0);
        end else begin : g_tx
            assign measured = room;
            assign drained  = (room == '0);
        end
    endgenerate

    assign hit = (measured >= trig);

endmodule

// File: rtl/trig_fifo_req.sv
// Module: trig_fifo_req
// Request outputs: irq follows the fill-point compare directly; dma_rdy rises
// with it and then holds until the drain boundary is reached.
// Assumes hit and drained come from registered state (no loop through here).
module trig_fifo_req (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic drained,
    output logic irq,
    output logic dma_rdy
);
    logic hold_q;

    assign irq     = hit;
    assign dma_rdy = hit || (hold_q && !drained);

    // Remember an active transfer request across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= dma_rdy;
    end

    // R8: the held request only drops at the drain boundary.
    assert_dma_drop_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_rdy) |-> drained);

endmodule

// File: rtl/trig_fifo.sv
// Module: trig_fifo (top)
// 64-entry character buffer with fill-point requests, receive or transmit form.
// Registers the buffering mode, treats a mode change like a clear, gates the
// valid/ready handshakes and ties together storage, threshold and request logic.
// Assumes the receive form is built with DATA_W = 11 and transmit with 8.
module trig_fifo #(
    parameter int unsigned IS_RX     = 1,
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned DATA_W    = 11,
    parameter int unsigned PROG_W    = 4,
    parameter int unsigned PROG_STEP = 4,
    parameter int unsigned LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              fifo_clr,
    input  logic [1:0]        trig_code,
    input  logic              trig_use_prog,
    input  logic [PROG_W-1:0] trig_prog,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              irq,
    output logic              dma_rdy
);
    logic en_q, clear, wr_do, rd_do, hit, drained;

    // Buffering mode register; off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    assign clear    = fifo_clr || (fifo_en != en_q);
    assign wr_ready = en_q ? (level != LVL_W'(DEPTH)) : 1'b1;
    assign rd_valid = (level != '0);
    assign wr_do    = wr_valid && wr_ready;
    assign rd_do    = rd_valid && rd_ready;

    trig_fifo_store #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .LVL_W (LVL_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_q   (en_q),
        .clear  (clear),
        .wr_do  (wr_do),
        .rd_do  (rd_do),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .level  (level)
    );

    trig_fifo_thresh #(
        .IS_RX    (IS_RX),
        .DEPTH    (DEPTH),
        .PROG_W   (PROG_W),
        .PROG_STEP(PROG_STEP),
        .LVL_W    (LVL_W)
    ) u_thresh (
        .en_q         (en_q),
        .trig_code    (trig_code),
        .trig_use_prog(trig_use_prog),
        .trig_prog    (trig_prog),
        .level        (level),
        .hit          (hit),
        .drained      (drained)
    );

    trig_fifo_req u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .drained(drained),
        .irq    (irq),
        .dma_rdy(dma_rdy)
    );

    // R10: a mode change leaves the buffer empty on the next cycle.
    assert_mode_change_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != en_q) |=> (level == '0));

    // R7: unbuffered receive form requests as soon as a character is held.
    assert_single_rx_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((IS_RX != 0) && !en_q && (level != '0)) |-> irq);

    // R7: unbuffered transmit form requests while the slot is free.
    assert_single_tx_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((IS_RX == 0) && !en_q && (level == '0)) |-> irq);

endmodule

// File: tb/trig_fifo_tb_top.sv
// Bench: drives a receive-form and a transmit-form instance with one stimulus
// and compares both against a queue model on every clock.
module trig_fifo_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0, fifo_clr = 1'b0, trig_use_prog = 1'b0;
    logic [1:0]  trig_code = 2'd0;
    logic [3:0]  trig_prog = 4'd0;
    logic        wr_valid = 1'b0, rd_ready = 1'b0;
    logic [10:0] wr_data = '0;

    logic        rx_wr_ready, rx_rd_valid, rx_irq, rx_dma;
    logic [10:0] rx_rd_data;
    logic [6:0]  rx_level;
    logic        tx_wr_ready, tx_rd_valid, tx_irq, tx_dma;
    logic [7:0]  tx_rd_data;
    logic [6:0]  tx_level;

    trig_fifo #(.IS_RX(1), .DATA_W(11)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
        .trig_code(trig_code), .trig_use_prog(trig_use_prog), .trig_prog(trig_prog),
        .wr_valid(wr_valid), .wr_ready(rx_wr_ready), .wr_data(wr_data),
        .rd_valid(rx_rd_valid), .rd_ready(rd_ready), .rd_data(rx_rd_data),
        .level(rx_level), .irq(rx_irq), .dma_rdy(rx_dma)
    );

    trig_fifo #(.IS_RX(0), .DATA_W(8)) dut_tx_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
        .trig_code(trig_code), .trig_use_prog(trig_use_prog), .trig_prog(trig_prog),
        .wr_valid(wr_valid), .wr_ready(tx_wr_ready), .wr_data(wr_data[7:0]),
        .rd_valid(tx_rd_valid), .rd_ready(rd_ready), .rd_data(tx_rd_data),
        .level(tx_level), .irq(tx_irq), .dma_rdy(tx_dma)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state.
    logic [10:0] m_q[$];
    bit m_en = 1'b0, m_hold_rx = 1'b0, m_hold_tx = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int trig_of(input bit rx);
        if (!m_en) return 1;
        if (trig_use_prog && trig_prog != 0) return 4 * int'(trig_prog);
        if (rx) begin
            case (trig_code) 2'd0: return 8; 2'd1: return 16; 2'd2: return 56; default: return 60; endcase
        end
        case (trig_code) 2'd0: return 8; 2'd1: return 16; 2'd2: return 32; default: return 56; endcase
    endfunction

    // One clock: compare outputs to the model, then advance the model at the edge.
    task automatic tick();
        int lvl, cap;
        bit e_wr, e_rv, e_hrx, e_htx, e_drx, e_dtx, clr, wacc, racc;
        #1;
        lvl   = m_q.size();
        cap   = m_en ? 64 : 1;
        e_wr  = m_en ? (lvl < 64) : 1'b1;
        e_rv  = (lvl > 0);
        e_hrx = (lvl >= trig_of(1'b1));
        e_htx = ((cap - lvl) >= trig_of(1'b0));
        e_drx = e_hrx || (m_hold_rx && lvl != 0);
        e_dtx = e_htx || (m_hold_tx && lvl != cap);
        if (rst_n) begin
            chk("R2/R4", "rx level", int'(rx_level), lvl);
            chk("R2/R4", "tx level", int'(tx_level), lvl);
            chk("R2/R4", "rx wr_ready", int'(rx_wr_ready), int'(e_wr));
            chk("R2/R4", "tx wr_ready", int'(tx_wr_ready), int'(e_wr));
            chk("R2", "rx rd_valid", int'(rx_rd_valid), int'(e_rv));
            chk("R2", "tx rd_valid", int'(tx_rd_valid), int'(e_rv));
            if (e_rv) begin
                chk("R3", "rx rd_data", int'(rx_rd_data), int'(m_q[0]));
                chk("R3", "tx rd_data", int'(tx_rd_data), int'(m_q[0][7:0]));
            end
            chk("R5/R6/R7", "rx irq", int'(rx_irq), int'(e_hrx));
            chk("R5/R6/R7", "tx irq", int'(tx_irq), int'(e_htx));
            chk("R8", "rx dma_rdy", int'(rx_dma), int'(e_drx));
            chk("R8", "tx dma_rdy", int'(tx_dma), int'(e_dtx));
        end
        @(posedge clk);
        if (!rst_n) begin
            m_q.delete();
            m_en = 1'b0; m_hold_rx = 1'b0; m_hold_tx = 1'b0;
        end else begin
            m_hold_rx = e_drx;
            m_hold_tx = e_dtx;
            clr  = fifo_clr || (fifo_en != m_en);
            wacc = wr_valid && e_wr;
            racc = rd_ready && e_rv;
            if (clr) begin
                m_q.delete();
            end else if (m_en) begin
                if (racc) void'(m_q.pop_front());
                if (wacc) m_q.push_back(wr_data);
            end else if (wacc) begin
                if (lvl == 1) m_q[0] = wr_data;
                else m_q.push_back(wr_data);
            end else if (racc) begin
                void'(m_q.pop_front());
            end
            m_en = fifo_en;
        end
        @(negedge clk);
    endtask

    task automatic rand_trig();
        trig_code     = 2'($urandom_range(0, 3));
        trig_use_prog = 1'($urandom_range(0, 1));
        trig_prog     = 4'($urandom_range(0, 15));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1: reset state of both forms.
        chk("R1", "rx level", int'(rx_level), 0);
        chk("R1", "rx wr_ready", int'(rx_wr_ready), 1);
        chk("R1", "rx rd_valid", int'(rx_rd_valid), 0);
        chk("R1", "rx irq", int'(rx_irq), 0);
        chk("R1", "rx dma_rdy", int'(rx_dma), 0);
        chk("R1", "tx irq", int'(tx_irq), 1);
        chk("R1", "tx dma_rdy", int'(tx_dma), 1);

        // R4: single holding register, overwrite and read-while-write.
        wr_valid = 1'b1; wr_data = 11'h5A1; tick();
        wr_data = 11'h2B3; tick();
        wr_valid = 1'b0; #1;
        chk("R4", "level after overwrite", int'(rx_level), 1);
        chk("R4", "held after overwrite", int'(rx_rd_data), 'h2B3);
        wr_valid = 1'b1; rd_ready = 1'b1; wr_data = 11'h7C4; tick();
        wr_valid = 1'b0; #1;
        chk("R4", "held after read+write", int'(rx_rd_data), 'h7C4);
        tick();
        rd_ready = 1'b0;
        for (int i = 0; i < 40; i++) begin
            wr_valid = 1'($urandom_range(0, 1)); rd_ready = 1'($urandom_range(0, 1));
            wr_data = 11'($urandom); rand_trig(); tick();
        end

        // R10: turning buffering on empties the held character.
        wr_valid = 1'b1; rd_ready = 1'b0; wr_data = 11'h111; tick();
        wr_valid = 1'b0; fifo_en = 1'b1; tick();
        #1; chk("R10", "level after enable", int'(rx_level), 0);

        // R2/R5/R6/R7: fill past full with trigger sources sweeping.
        for (int i = 0; i < 72; i++) begin
            wr_valid = 1'b1; wr_data = 11'($urandom);
            trig_code = 2'(i % 4); trig_use_prog = 1'((i / 4) % 2);
            trig_prog = (i % 3 == 0) ? 4'd0 : 4'((i * 7) % 16);
            tick();
        end
        wr_valid = 1'b0; #1;
        chk("R2", "full level", int'(rx_level), 64);
        chk("R2", "full wr_ready", int'(rx_wr_ready), 0);
        // Drain with sweeping triggers.
        for (int i = 0; i < 70; i++) begin
            rd_ready = 1'b1;
            trig_code = 2'((i / 2) % 4); trig_use_prog = 1'(i % 2);
            trig_prog = 4'((i * 5) % 16);
            tick();
        end
        rd_ready = 1'b0;

        // Random mixed traffic with rare clears; bias phases toward fill or drain.
        for (int i = 0; i < 600; i++) begin
            int bias = (i / 100) % 2;
            wr_valid = ($urandom_range(0, 9) < (bias ? 7 : 3));
            rd_ready = ($urandom_range(0, 9) < (bias ? 3 : 7));
            wr_data  = 11'($urandom);
            fifo_clr = ($urandom_range(0, 79) == 0);
            if (i % 5 == 0) rand_trig();
            tick();
        end
        fifo_clr = 1'b0;

        // R9: clear wins over a concurrent write.
        wr_valid = 1'b1; rd_ready = 1'b0;
        repeat (5) tick();
        fifo_clr = 1'b1; tick();
        fifo_clr = 1'b0; wr_valid = 1'b0; #1;
        chk("R9", "level after clear", int'(rx_level), 0);

        // R10: turning buffering off with data held empties it.
        wr_valid = 1'b1; repeat (4) tick();
        wr_valid = 1'b0; fifo_en = 1'b0; tick();
        #1; chk("R10", "level after disable", int'(rx_level), 0);

        // Random traffic with occasional mode changes.
        for (int i = 0; i < 400; i++) begin
            wr_valid = 1'($urandom_range(0, 1));
            rd_ready = 1'($urandom_range(0, 1));
            wr_data  = 11'($urandom);
            if ($urandom_range(0, 59) == 0) fifo_en = ~fifo_en;
            if (i % 7 == 0) rand_trig();
            tick();
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule